// File: doc/BRIEF.md
# Signed-Digit Redundant Adder

This block adds two radix-2 signed-digit operands of `N` digits each, where every digit takes one of the values -1, 0 or +1. The sum has `N+1` digits in the same redundant form. No carry travels more than one position, so the logic depth from operand to result is the same for any `N`. Each digit is carried on three wires with exactly one wire high.

Addition takes three combinational steps for each position. First, the two operand digits are summed into a preliminary value in the range -2..2. Second, that value is split into a transfer that moves up one position and an interim digit. This split also looks at the sign of the preliminary value one position lower, which keeps the later step inside the digit set. Third, the interim digit is added to the transfer coming from below. The result is captured in a register whenever the input strobe is high. A separate helper converts a signed-digit vector to two's complement. It serves checking only and stays off the adder's path.

A typical use is an accumulation or multiply stage that keeps intermediate values redundant and converts once at the end.

Top module: `sd_redundant_adder`

## Requirements
- R1: Each digit occupies a 3-bit field, with digit k at bits [3k+2:3k] and digit 0 least significant. The codes are 3'b001 for +1, 3'b010 for 0 and 3'b100 for -1.
- R2: Treat an invalid field as 0. After an accepted cycle, the two's-complement value of `sum_dig` (sum over k of digit_k·2^k, across N+1 digits) equals the value of `a_dig` plus the value of `b_dig`.
- R3: Every field of `sum_dig` always holds one of the three legal codes.
- R4: `sum_valid` goes high on the rising edge after a cycle with `in_valid` high. It is low after a cycle with `in_valid` low.
- R5: While `in_valid` is low, `sum_dig` keeps its previous value, whatever the operand inputs do.
- R6: On the edge that captures an accepted cycle, `code_err` is set high if any operand field of that cycle is not one of the three legal codes. In every other case it is low.
- R7: Reset is synchronous and active-high. It clears `sum_valid` and `code_err`, and sets every result field to the zero code 3'b010.
- R8: Result digit i depends only on operand positions i, i-1 and i-2. A change to operand digits at position j or above leaves result digits below j unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands are present this cycle |
| a_dig | input | 3*N | First operand, one-hot coded digits |
| b_dig | input | 3*N | Second operand, one-hot coded digits |
| sum_dig | output | 3*(N+1) | Registered redundant sum |
| sum_valid | output | 1 | `sum_dig` was updated on the last edge |
| code_err | output | 1 | An operand field of the captured cycle was not one-hot |

## Verification
A wrong transfer/interim split, or a wrong lookahead choice, shows up in one of two ways on the cycle after capture. The two's-complement value of `sum_dig` can differ from the operand sum. Or a result field can leave the legal code set, because two digits of the same sign met in the final step. An exhaustive sweep of every legal operand pair at four digits exposes both at the first affected pair. Locality faults appear as low result digits that change when only high operand digits change. Faults in the hold and flag registers appear on the very next idle or malformed cycle.

// File: rtl/sdadd_pkg.sv
package sdadd_pkg;

  typedef logic [2:0]        sdig_t;
  typedef logic signed [2:0] pval_t;
  typedef logic signed [1:0] tval_t;

  localparam sdig_t SD_POS  = 3'b001;
  localparam sdig_t SD_ZERO = 3'b010;
  localparam sdig_t SD_NEG  = 3'b100;

  function automatic tval_t sd_value(input sdig_t d);
    case (d)
      SD_POS:  return 2'b01;
      SD_NEG:  return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic sd_legal(input sdig_t d);
    return (d == SD_POS) || (d == SD_ZERO) || (d == SD_NEG);
  endfunction

  function automatic sdig_t sd_encode(input tval_t v);
    case (v)
      2'b01:   return SD_POS;
      2'b11:   return SD_NEG;
      default: return SD_ZERO;
    endcase
  endfunction

endpackage

// File: rtl/sdadd_pos_sum.sv
module sdadd_pos_sum
  import sdadd_pkg::*;
(
  input  sdig_t a_d,
  input  sdig_t b_d,
  output pval_t p,
  output logic  bad
);
  tval_t va, vb;

  always_comb begin
    va  = sd_value(a_d);
    vb  = sd_value(b_d);
    p   = {va[1], va} + {vb[1], vb};
    bad = !sd_legal(a_d) || !sd_legal(b_d);
  end
endmodule

// File: rtl/sdadd_split.sv
module sdadd_split
  import sdadd_pkg::*;
(
  input  pval_t p_here,
  input  logic  low_pos,
  output tval_t t,
  output tval_t w
);
  always_comb begin
    case (p_here)
      3'sd2: begin t = 2'sb01; w = 2'sb00; end
      -3'sd2: begin t = 2'sb11; w = 2'sb00; end
      3'sd1: begin
        if (low_pos) begin t = 2'sb01; w = 2'sb11; end
        else         begin t = 2'sb00; w = 2'sb01; end
      end
      -3'sd1: begin
        if (low_pos) begin t = 2'sb00; w = 2'sb11; end
        else         begin t = 2'sb11; w = 2'sb01; end
      end
      default: begin t = 2'sb00; w = 2'sb00; end
    endcase
  end
endmodule

// File: rtl/sdadd_final.sv
module sdadd_final
  import sdadd_pkg::*;
(
  input  tval_t w,
  input  tval_t t_in,
  output sdig_t d
);
  logic signed [2:0] s;

  always_comb begin
    s = {w[1], w} + {t_in[1], t_in};
    case (s)
      3'sb001: d = SD_POS;
      3'sb111: d = SD_NEG;
      default: d = SD_ZERO;
    endcase
  end
endmodule

// File: rtl/sdadd_to_twos.sv
module sdadd_to_twos
  import sdadd_pkg::*;
#(
  parameter int D = 4,
  parameter int W = D + 2
) (
  input  logic [3*D-1:0]  dig,
  output logic signed [W-1:0] val
);
  logic [W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int k = 0; k < D; k++) begin
      if (dig[3*k +: 3] == SD_POS)
        acc = acc + (W'(1) << k);
      else if (dig[3*k +: 3] == SD_NEG)
        acc = acc - (W'(1) << k);
    end
    val = signed'(acc);
  end
endmodule

// File: rtl/sd_redundant_adder.sv
module sd_redundant_adder
  import sdadd_pkg::*;
#(
  parameter int N = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [3*N-1:0]   a_dig,
  input  logic [3*N-1:0]   b_dig,
  output logic [3*N+2:0]   sum_dig,
  output logic             sum_valid,
  output logic             code_err
);
  localparam int OW = 3 * (N + 1);
  localparam int VW = N + 3;

  pval_t          p [N];
  tval_t          t [N];
  tval_t          w [N];
  logic [N-1:0]   bad;
  logic [OW-1:0]  next_sum;

  generate
    for (genvar i = 0; i < N; i++) begin : g_pos
      logic  low_pos;
      tval_t t_in;

      sdadd_pos_sum u_ps (
        .a_d (a_dig[3*i +: 3]),
        .b_d (b_dig[3*i +: 3]),
        .p   (p[i]),
        .bad (bad[i])
      );

      if (i == 0) begin : g_lsb
        assign low_pos = 1'b0;
        assign t_in    = 2'sb00;
      end else begin : g_up
        assign low_pos = (p[i-1] > 0);
        assign t_in    = t[i-1];
      end

      sdadd_split u_sp (
        .p_here  (p[i]),
        .low_pos (low_pos),
        .t       (t[i]),
        .w       (w[i])
      );

      sdadd_final u_fd (
        .w    (w[i]),
        .t_in (t_in),
        .d    (next_sum[3*i +: 3])
      );

      // R3: interim digit and incoming transfer never share a nonzero sign
      a_r3_closed: assert property (@(posedge clk) disable iff (rst)
        in_valid |-> !((w[i] == t_in) && (w[i] != 2'sb00)));
    end
  endgenerate

  assign next_sum[3*N +: 3] = sd_encode(t[N-1]);

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_dig   <= {(N+1){SD_ZERO}};
      sum_valid <= 1'b0;
      code_err  <= 1'b0;
    end else begin
      sum_valid <= in_valid;
      code_err  <= in_valid & (|bad);
      if (in_valid)
        sum_dig <= next_sum;
    end
  end

  // Checking-only conversion of operands and result
  logic signed [VW-1:0] a_val, b_val, s_val, ab_val;
  logic                 sum_ok;

  sdadd_to_twos #(.D(N),   .W(VW)) u_cva (.dig(a_dig),   .val(a_val));
  sdadd_to_twos #(.D(N),   .W(VW)) u_cvb (.dig(b_dig),   .val(b_val));
  sdadd_to_twos #(.D(N+1), .W(VW)) u_cvs (.dig(sum_dig), .val(s_val));

  assign ab_val = a_val + b_val;

  always_comb begin
    sum_ok = 1'b1;
    for (int k = 0; k <= N; k++)
      if (!$onehot(sum_dig[3*k +: 3])) sum_ok = 1'b0;
  end

  a_r2_value: assert property (@(posedge clk) disable iff (rst)
    sum_valid |-> (s_val == $past(ab_val)));

  a_r3_onehot: assert property (@(posedge clk) disable iff (rst)
    sum_ok);

  a_r4_valid_set: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> sum_valid);

  a_r4_valid_clr: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !sum_valid);

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(sum_dig));

  a_r6_err_set: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (|bad)) |=> code_err);

  a_r6_err_clr: assert property (@(posedge clk) disable iff (rst)
    !(in_valid && (|bad)) |=> !code_err);

endmodule

// File: tb/sd_redundant_adder_test.sv
`timescale 1ns/1ps
module sd_redundant_adder_test;
  localparam int N  = 4;
  localparam int DW = 3 * N;
  localparam int OW = 3 * (N + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [DW-1:0] a_dig = '0;
  logic [DW-1:0] b_dig = '0;
  logic [OW-1:0] sum_dig;
  logic          sum_valid;
  logic          code_err;

  int total = 0;
  int bad   = 0;
  bit finished = 1'b0;

  sd_redundant_adder #(.N(N)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_dig(a_dig), .b_dig(b_dig),
    .sum_dig(sum_dig), .sum_valid(sum_valid), .code_err(code_err)
  );

  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [2:0] code_of(input int v);
    if (v > 0) return 3'b001;
    if (v < 0) return 3'b100;
    return 3'b010;
  endfunction

  function automatic logic [DW-1:0] pack(input int idx);
    logic [DW-1:0] r;
    int x = idx;
    for (int k = 0; k < N; k++) begin
      r[3*k +: 3] = code_of((x % 3) - 1);
      x = x / 3;
    end
    return r;
  endfunction

  function automatic int op_value(input logic [DW-1:0] x);
    int v = 0;
    for (int k = 0; k < N; k++) begin
      if (x[3*k +: 3] == 3'b001) v += (1 << k);
      else if (x[3*k +: 3] == 3'b100) v -= (1 << k);
    end
    return v;
  endfunction

  function automatic int out_value(input logic [OW-1:0] x);
    int v = 0;
    for (int k = 0; k <= N; k++) begin
      if (x[3*k +: 3] == 3'b001) v += (1 << k);
      else if (x[3*k +: 3] == 3'b100) v -= (1 << k);
    end
    return v;
  endfunction

  function automatic bit out_legal(input logic [OW-1:0] x);
    for (int k = 0; k <= N; k++)
      if (x[3*k +: 3] != 3'b001 && x[3*k +: 3] != 3'b010 && x[3*k +: 3] != 3'b100)
        return 1'b0;
    return 1'b1;
  endfunction

  // present one accepted cycle; returns at the negedge after the capture edge
  task automatic drive(input logic [DW-1:0] a, input logic [DW-1:0] b);
    @(negedge clk);
    a_dig = a; b_dig = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic summary;
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    logic [OW-1:0] saved;
    logic [DW-1:0] a1, a2, bb;
    logic [8:0]    low1;
    int exp_v;

    repeat (3) @(negedge clk);
    // R7: reset state
    check(sum_valid == 1'b0, "R7 reset sum_valid", int'(sum_valid), 0);
    check(code_err == 1'b0, "R7 reset code_err", int'(code_err), 0);
    check(sum_dig == {(N+1){3'b010}}, "R7 reset digits", int'(sum_dig), int'({(N+1){3'b010}}));
    rst = 1'b0;

    // R1: literal codes
    drive({N{3'b010}}, {N{3'b010}});
    check(sum_dig == {(N+1){3'b010}}, "R1 zero sum", int'(sum_dig), int'({(N+1){3'b010}}));
    drive({{(N-1){3'b010}}, 3'b001}, {N{3'b010}});
    check(sum_dig == {{N{3'b010}}, 3'b001}, "R1 plus one", int'(sum_dig), int'({{N{3'b010}}, 3'b001}));
    drive({N{3'b001}}, {N{3'b001}});
    check(sum_dig == {{N{3'b001}}, 3'b010}, "R1 all plus", int'(sum_dig), int'({{N{3'b001}}, 3'b010}));

    // R2/R3/R4/R6: exhaustive sweep of legal operands
    for (int ia = 0; ia < 81; ia++) begin
      for (int ib = 0; ib < 81; ib++) begin
        drive(pack(ia), pack(ib));
        exp_v = op_value(pack(ia)) + op_value(pack(ib));
        check(out_value(sum_dig) == exp_v, "R2 value", out_value(sum_dig), exp_v);
        check(out_legal(sum_dig), "R3 legal digits", int'(sum_dig), 0);
        check(sum_valid == 1'b1, "R4 valid after accept", int'(sum_valid), 1);
        check(code_err == 1'b0, "R6 no error on legal", int'(code_err), 0);
      end
    end

    // R4: idle cycle drops valid
    @(negedge clk);
    check(sum_valid == 1'b0, "R4 valid after idle", int'(sum_valid), 0);

    // R5: hold while idle with moving inputs
    saved = sum_dig;
    for (int c = 0; c < 4; c++) begin
      a_dig = pack(10 + 17 * c); b_dig = pack(70 - 9 * c);
      @(negedge clk);
      check(sum_dig == saved, "R5 hold", int'(sum_dig), int'(saved));
    end

    // R6: malformed codes at several positions
    for (int c = 0; c < 5; c++) begin
      logic [2:0] badc;
      case (c)
        0: badc = 3'b000; 1: badc = 3'b011; 2: badc = 3'b101;
        3: badc = 3'b110; default: badc = 3'b111;
      endcase
      a1 = pack(13 + 11 * c); bb = pack(60 - 7 * c);
      if (c % 2 == 0) a1[3*(c % N) +: 3] = badc;
      else bb[3*(c % N) +: 3] = badc;
      drive(a1, bb);
      exp_v = op_value(a1) + op_value(bb);
      check(code_err == 1'b1, "R6 error flagged", int'(code_err), 1);
      check(out_value(sum_dig) == exp_v, "R6 invalid as zero", out_value(sum_dig), exp_v);
    end
    drive(pack(5), pack(33));
    check(code_err == 1'b0, "R6 error clears on legal", int'(code_err), 0);
    a_dig = {N{3'b111}};
    @(negedge clk);
    check(code_err == 1'b0, "R6 no error when idle", int'(code_err), 0);

    // R8: top operand digit does not reach result digits 0..2
    for (int ia = 0; ia < 27; ia++) begin
      for (int hv = -1; hv <= 1; hv++) begin
        bb = pack(80 - 3 * ia);
        a1 = pack(ia);
        a2 = a1; a2[3*3 +: 3] = code_of(hv);
        drive(a1, bb);
        low1 = sum_dig[8:0];
        drive(a2, bb);
        check(sum_dig[8:0] == low1, "R8 locality a", int'(sum_dig[8:0]), int'(low1));
        a2 = bb; a2[3*3 +: 3] = code_of(-hv);
        drive(a1, a2);
        check(sum_dig[8:0] == low1, "R8 locality b", int'(sum_dig[8:0]), int'(low1));
      end
    end

    // R7: reset during operation wins over an accepted cycle
    drive({N{3'b001}}, {N{3'b001}});
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b1;
    a_dig = {N{3'b100}}; b_dig = {N{3'b111}};
    @(negedge clk);
    check(sum_valid == 1'b0, "R7 mid reset valid", int'(sum_valid), 0);
    check(code_err == 1'b0, "R7 mid reset error", int'(code_err), 0);
    check(sum_dig == {(N+1){3'b010}}, "R7 mid reset digits", int'(sum_dig), int'({(N+1){3'b010}}));
    in_valid = 1'b0; rst = 1'b0;
    @(negedge clk);

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule